// File: doc/BRIEF.md
# Write-only two-wire current-code target

This block is a two-wire serial (I2C) target that only accepts writes. A controller sends an address byte whose upper five bits are fixed and whose two low address bits come from a board strap. It then sends any number of data bytes, and each one replaces a single 8-bit current code. The code drives an external current-sink DAC. A code of zero turns the sink off. Any other code asks for code × 500 µA. The bus lines are oversampled on a faster system clock. The block acknowledges by pulling an open-drain data line low.

A supply-fault input clears the code. An active-low sleep input holds the serial logic idle and forces the sink enable off while it is low. The code value is kept through sleep. The analog DAC, the sink transistor and the detection of supply faults are outside this block. A fault arrives here as a plain digital level.

Top module: `vcm_code_target`

## Requirements
- R1: The address byte is acknowledged only when its bits [7:3] equal 5'b00011, its bits [2:1] equal `strap_sel`, and bit 0 (read/write, 0 = write) is 0. That gives the write bytes 0x18, 0x1A, 0x1C and 0x1E.
- R2: An address byte with bit 0 = 1 (read) is not acknowledged, and the code register is not changed by the bytes that follow it.
- R3: After each 8-bit data byte that follows an acknowledged address, the block drives `sda_oe` high for the whole of the 9th SCL clock.
- R4: Data is shifted MSB first. The first data bit on the wire becomes `code_q[7]` and the last becomes `code_q[0]`. The code takes the new value once the 8th SCL falling edge has been seen.
- R5: Several data bytes may follow one address before STOP. Each completed byte overwrites `code_q`.
- R6: A START or STOP that arrives part way through a byte drops that byte and leaves `code_q` unchanged. After a repeated START, a fresh address is expected.
- R7: `out_en` is 1 exactly when `code_q` is nonzero, `sleep_n` is high and `supply_fault` is low. A code of 0 gives `out_en` = 0.
- R8: While `supply_fault` is high, `code_q` is 0 from the next clock edge onward, and it stays 0 until a new byte is written.
- R9: While `sleep_n` is low, `out_en` and `sda_oe` are 0 and no byte is acknowledged or loaded. `code_q` keeps its value.
- R10: After an address byte that is not acknowledged, the block stays off the bus. It acknowledges no data and loads no data until the next START.
- R11: `sda_oe` changes only while the synchronized SCL is low.
- R12: After reset, `code_q` = 0, `out_en` = 0 and `sda_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 = pull the data line low (open drain) |
| strap_sel | input | 2 | Sets the two low address bits |
| sleep_n | input | 1 | Active-low sleep |
| supply_fault | input | 1 | Supply fault; clears the code |
| code_q | output | 8 | Current code for the sink DAC |
| out_en | output | 1 | Sink enable |

## Verification
Most wrong states inside the block show at the ports within one byte time. A shift counter that is off by one moves the acknowledge out of the 9th clock, which the controller sees as a missing acknowledge. It also loads a code rotated by one bit. If the sequence is not restarted on START or STOP, the next write loads a mixed code or acknowledges the wrong byte. If a non-matching or read address is not held off the bus, the block acknowledges bytes meant for another target. If the enable is not forced off by a fault or by sleep, `out_en` shows it on the very next clock.

// File: rtl/vcmt_pkg.sv
package vcmt_pkg;
  typedef enum logic [2:0] {
    LK_IDLE,
    LK_ADDR,
    LK_ADDR_ACK,
    LK_DATA,
    LK_DATA_ACK,
    LK_SKIP
  } link_st_t;
endpackage

// File: rtl/vcmt_sync.sv
module vcmt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= '1;
    else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/vcmt_cond_det.sv
module vcmt_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/vcmt_link.sv
module vcmt_link
  import vcmt_pkg::*;
#(
  parameter int         BYTE_W  = 8,
  parameter int         STRAP_W = 2,
  parameter logic [4:0] ADDR_HI = 5'b00011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [STRAP_W-1:0] strap_sel,
  output logic              sda_oe,
  output logic              load_stb,
  output logic [BYTE_W-1:0] load_byte
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W);

  link_st_t          st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg;
  logic              addr_hit;
  logic              byte_done;

  assign addr_hit  = (shreg[BYTE_W-1 -: 5] == ADDR_HI) &&
                     (shreg[STRAP_W:1] == strap_sel) && !shreg[0];
  assign byte_done = scl_fall && (cnt == LAST);
  assign load_stb  = sleep_n && !start_det && !stop_det &&
                     (st == LK_DATA) && byte_done;
  assign load_byte = shreg;

  always_ff @(posedge clk) begin
    if (rst || !sleep_n) begin
      st     <= LK_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= LK_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= LK_IDLE;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        LK_ADDR, LK_DATA: begin
          if (scl_rise && cnt != LAST) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
          end
          if (byte_done) begin
            if (st == LK_DATA) begin
              st     <= LK_DATA_ACK;
              sda_oe <= 1'b1;
            end else if (addr_hit) begin
              st     <= LK_ADDR_ACK;
              sda_oe <= 1'b1;
            end else begin
              st <= LK_SKIP;
            end
          end
        end
        LK_ADDR_ACK, LK_DATA_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            st     <= LK_DATA;
            cnt    <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  // R11: the data line only moves while SCL is low (sleep may force release)
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (rst)
    ((sda_oe != $past(sda_oe)) && $past(sleep_n)) |-> !$past(scl_s));
  // R3: every load is followed by an acknowledge
  p_load_acks_r3: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> sda_oe);
  // R9: sleep releases the bus
  p_sleep_release_r9: assert property (@(posedge clk) disable iff (rst)
    !sleep_n |=> !sda_oe);
endmodule

// File: rtl/vcm_code_target.sv
module vcm_code_target #(
  parameter int         CODE_W      = 8,
  parameter int         STRAP_W     = 2,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_HI     = 5'b00011
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [STRAP_W-1:0] strap_sel,
  input  logic              sleep_n,
  input  logic              supply_fault,
  output logic [CODE_W-1:0] code_q,
  output logic              out_en
);
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic              load_stb;
  logic [CODE_W-1:0] load_byte;
  logic [CODE_W-1:0] code_nx;

  vcmt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({scl_i, sda_i}),
    .dout({scl_s, sda_s})
  );

  vcmt_cond_det u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  vcmt_link #(.BYTE_W(CODE_W), .STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) u_link (
    .clk      (clk),
    .rst      (rst),
    .sleep_n  (sleep_n),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .strap_sel(strap_sel),
    .sda_oe   (sda_oe),
    .load_stb (load_stb),
    .load_byte(load_byte)
  );

  always_comb begin
    code_nx = code_q;
    if (supply_fault)  code_nx = '0;
    else if (load_stb) code_nx = load_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      out_en <= 1'b0;
    end else begin
      code_q <= code_nx;
      out_en <= sleep_n && !supply_fault && (code_nx != '0);
    end
  end

  // R8: a fault leaves the code at zero
  p_fault_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $past(supply_fault) |-> (code_q == '0));
  // R7: the enable implies a nonzero code
  p_en_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    out_en |-> (code_q != '0));
  // R9: sleep forces the enable off
  p_sleep_en_off_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(sleep_n) |-> !out_en);
endmodule

// File: tb/vcm_code_target_bench.sv
module vcm_code_target_bench;
  localparam int HALF = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'd0;
  logic       sleep_n = 1'b1, fault = 1'b0;
  logic       sda_oe, out_en;
  logic [7:0] code_q;
  logic       sda_bus;
  int         total = 0, bad = 0;
  bit         done = 1'b0;
  logic [7:0] exp_code = 8'd0;

  assign sda_bus = sda_m & ~sda_oe;
  always #4 clk = ~clk;

  vcm_code_target u_vcm_code_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_sel(strap), .sleep_n(sleep_n), .supply_fault(fault),
    .code_q(code_q), .out_en(out_en)
  );

  function automatic bit addr_ok(input logic [7:0] a, input logic [1:0] s);
    return (a[7:3] == 5'b00011) && (a[2:1] == s) && !a[0];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(HALF); scl_m = 1'b1; wt(HALF);
    sda_m = 1'b0; wt(HALF); scl_m = 1'b0; wt(HALF);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(HALF); scl_m = 1'b1; wt(HALF); sda_m = 1'b1; wt(HALF);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wt(HALF); scl_m = 1'b1; wt(HALF); scl_m = 1'b0; wt(HALF);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wt(HALF); scl_m = 1'b1; wt(HALF);
    ack = !sda_bus;
    scl_m = 1'b0; wt(HALF);
  endtask

  // full write transfer with checks against the bench model
  task automatic write_xfer(input logic [7:0] a, input logic [7:0] d[], input string tag);
    bit ack, aok;
    aok = addr_ok(a, strap) && sleep_n;
    i2c_start();
    send_byte(a, ack);
    chk(ack == aok, {tag, " R1 addr ack"}, ack, aok);
    foreach (d[k]) begin
      send_byte(d[k], ack);
      chk(ack == aok, {tag, " R3/R10 data ack"}, ack, aok);
      if (aok && !fault) exp_code = d[k];
      chk(code_q == exp_code, {tag, " R4/R5 code"}, code_q, exp_code);
      chk(out_en == (exp_code != 0 && sleep_n && !fault), {tag, " R7 out_en"}, out_en,
          (exp_code != 0 && sleep_n && !fault));
    end
    i2c_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R12 act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d[];
    bit ack;
    void'($urandom(32'd2024));
    wt(5); rst = 1'b0; wt(2);
    chk(code_q == 0, "R12 reset code", code_q, 0);
    chk(out_en == 0, "R12 reset out_en", out_en, 0);
    chk(sda_oe == 0, "R12 reset sda_oe", sda_oe, 0);

    // R4 MSB first, R5 overwrite, R7 zero code
    d = '{8'hA5, 8'h01, 8'h00, 8'h80};
    write_xfer(8'h18, d, "dir0");
    // R1 each strap value
    for (int s = 0; s < 4; s++) begin
      strap = s[1:0];
      d = '{8'(8'h30 + s)};
      write_xfer(8'h18 | 8'(s << 1), d, "strap");
      d = '{8'h77};
      write_xfer(8'h18 | 8'(((s + 1) % 4) << 1), d, "strapmiss");
    end
    strap = 2'd1;
    // R2 read request
    d = '{8'h55};
    write_xfer(8'h1B, d, "R2 read");
    chk(code_q == exp_code, "R2 code kept", code_q, exp_code);

    // R6 stop mid-byte
    i2c_start(); send_byte(8'h1A, ack); send_bits(8'hFF, 4); i2c_stop();
    chk(code_q == exp_code, "R6 stop abort", code_q, exp_code);
    // R6 repeated start mid-byte
    i2c_start(); send_byte(8'h1A, ack); send_bits(8'h0F, 5);
    i2c_start(); send_byte(8'h1A, ack);
    chk(ack, "R6 addr after restart", ack, 1);
    send_byte(8'hC3, ack); exp_code = 8'hC3;
    chk(code_q == 8'hC3, "R6 code after restart", code_q, 8'hC3);
    i2c_stop();

    // R8 fault
    fault = 1'b1; wt(2);
    chk(code_q == 0, "R8 fault clears", code_q, 0);
    chk(out_en == 0, "R8 fault out_en", out_en, 0);
    fault = 1'b0; wt(2); exp_code = 0;
    chk(code_q == 0, "R8 stays zero", code_q, 0);
    d = '{8'h44}; write_xfer(8'h1A, d, "R8 rewrite");

    // R9 sleep
    sleep_n = 1'b0; wt(2);
    chk(out_en == 0, "R9 out_en off", out_en, 0);
    chk(code_q == 8'h44, "R9 code kept", code_q, 8'h44);
    d = '{8'h99}; write_xfer(8'h1A, d, "R9 asleep");
    sleep_n = 1'b1; wt(2);
    chk(out_en == 1, "R9 wake out_en", out_en, 1);

    // random mix
    for (int it = 0; it < 30; it++) begin
      logic [7:0] a;
      int n;
      a = ($urandom % 3 != 0) ? (8'h18 | 8'(strap << 1)) : 8'($urandom);
      n = 1 + $urandom % 3;
      d = new[n];
      foreach (d[k]) d[k] = 8'($urandom);
      if (it % 7 == 3) d[0] = 8'h00;
      write_xfer(a, d, "rand");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule